// File: doc/BRIEF.md
# Card Clock Generator

This block derives the clock that drives a memory card bus from the host's master clock. A single configuration word, written through one write port, holds the divider value, the generator on/off bit, an idle-power-saving bit, a bypass bit, a bit that lets the data FIFO pause the card clock, and a bus-width code. A parameter fixes which of two divider laws the instance implements: an even law, or an integer law that can produce odd periods.

Every configuration change that affects the waveform is deferred to the next period boundary. A boundary is the end of the low phase of the card clock, or any cycle in which the clock is parked. At each boundary the generator decides whether the next period runs. It runs only when the clock is enabled, no FIFO stall is active with flow control on, and, with power saving on, the command or data path reports busy. The rest of the host gets a one-cycle tick at every rising edge of the card clock, so it can stay in the master clock domain. It also gets the decoded bus width.

Top module: `cclk_gen`

## Requirements
- R1: After a synchronous active-low reset, `cardClk` and `clkTick` are low and `busWidth` is 0.
- R2: With `ALT_DIV`=0 and divider value d, each period lasts 2×(d+1) master cycles: d+1 cycles high, then d+1 cycles low.
- R3: With `ALT_DIV`=1 and divider value d, each period lasts d+2 master cycles: floor((d+2)/2) cycles high, and the rest low.
- R4: With the bypass bit set, `cardClk` follows the master clock and `clkTick` is high in every running cycle, whatever the divider value.
- R5: Clearing the enable bit lets the current period finish. The clock then parks low and stays low with no ticks.
- R6: With flow control on, a `fifoStall` seen at a boundary parks the clock low until the stall drops. With flow control off, `fifoStall` has no effect.
- R7: With power saving on, a period starts only at a boundary where `pathBusy` is high.
- R8: A new divider value or bypass setting takes effect only at the next boundary. The period in progress keeps its length, so no shortened pulse appears.
- R9: `clkTick` is high for exactly one master cycle, namely the cycle in which a period starts. That is the cycle in which `cardClk` rises.
- R10: The bus-width code in bits 13:12 gives `busWidth`: 00→0 (1-bit), 01→1 (4-bit), 10→2 (8-bit). The unused code 11 gives 0 (1-bit). `busWidth` updates the cycle after the write.
- R11: The configuration word holds the divider in bits 7:0, enable in bit 8, power save in bit 9, bypass in bit 10 and flow control in bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the configuration word |
| cfgWrData | input | 14 | Configuration word |
| fifoStall | input | 1 | Data FIFO cannot accept or supply data |
| pathBusy | input | 1 | Command or data path is active |
| cardClk | output | 1 | Card clock |
| clkTick | output | 1 | One-cycle strobe at each card clock rising edge |
| busWidth | output | 2 | Decoded bus width: 0=1-bit, 1=4-bit, 2=8-bit |

## Verification
The bench drives two instances, one for each divider law. Both are compared every half master cycle against a behavioural period model. The sequence rewrites the divider in the middle of a period: a design that applied it at once would cut the high or low phase short. It also drops enable, raises a stall and lowers busy in the middle of a period: a design that stopped the clock at once would leave a truncated pulse. Odd alternate-law periods catch a wrong rounding of the high phase. Stall pulses with flow control off catch gating that is always on. The unused width code catches a decoder that passes the raw bits through.

// File: rtl/cclk_gen_pkg.sv
package cclk_gen_pkg;

  // Strobes from the control half to the waveform datapath, valid at a boundary.
  typedef struct packed {
    logic go;    // start a new card clock period
    logic park;  // hold the clock low for this cycle
  } cclkStrobe_t;

  typedef enum logic [1:0] {
    BW_1BIT = 2'd0,
    BW_4BIT = 2'd1,
    BW_8BIT = 2'd2
  } busWidth_e;

endpackage

// File: rtl/cclk_gen_ctrl.sv
module cclk_gen_ctrl
  import cclk_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int ALT_DIV = 0,
  localparam int CFG_W  = DIV_W + 6,
  localparam int PER_W  = DIV_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              fifoStall,
  input  logic              pathBusy,
  input  logic              atBoundary,
  output cclkStrobe_t       strobe,
  output logic [PER_W-1:0]  perNew,
  output logic              bypNew,
  output logic [1:0]        busWidth
);

  localparam int EN_BIT   = DIV_W;
  localparam int PS_BIT   = DIV_W + 1;
  localparam int BYP_BIT  = DIV_W + 2;
  localparam int FLOW_BIT = DIV_W + 3;
  localparam int BW_LO    = DIV_W + 4;

  logic [CFG_W-1:0] cfgQ;
  logic [DIV_W-1:0] divVal;
  logic             enBit, psBit, flowBit;
  logic [1:0]       widthCode;
  logic             runOk;
  logic [PER_W-1:0] divWide;
  logic [PER_W-1:0] perDiv;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfgWrData;
  end

  assign divVal    = cfgQ[DIV_W-1:0];
  assign enBit     = cfgQ[EN_BIT];
  assign psBit     = cfgQ[PS_BIT];
  assign bypNew    = cfgQ[BYP_BIT];
  assign flowBit   = cfgQ[FLOW_BIT];
  assign widthCode = cfgQ[BW_LO+1:BW_LO];
  assign divWide   = {{(PER_W-DIV_W){1'b0}}, divVal};

  generate
    if (ALT_DIV != 0) begin : g_altLaw
      assign perDiv = divWide + PER_W'(2);
    end else begin : g_stdLaw
      assign perDiv = (divWide + PER_W'(1)) << 1;
    end
  endgenerate

  assign perNew = bypNew ? PER_W'(1) : perDiv;

  always_comb begin
    runOk = enBit;
    if (flowBit && fifoStall) runOk = 1'b0;
    if (psBit && !pathBusy)   runOk = 1'b0;
  end

  always_comb begin
    strobe.go   = atBoundary && runOk;
    strobe.park = atBoundary && !runOk;
  end

  always_comb begin
    unique case (widthCode)
      2'b01:   busWidth = BW_4BIT;
      2'b10:   busWidth = BW_8BIT;
      default: busWidth = BW_1BIT;
    endcase
  end

  // R6
  flow_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[FLOW_BIT] && fifoStall) |-> !strobe.go);

  // R7
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[PS_BIT] && !pathBusy) |-> !strobe.go);

  // R10
  width_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWidth != 2'b11);

endmodule

// File: rtl/cclk_gen_dp.sv
module cclk_gen_dp
  import cclk_gen_pkg::*;
#(
  parameter int DIV_W  = 8,
  localparam int PER_W = DIV_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cclkStrobe_t       strobe,
  input  logic [PER_W-1:0]  perNew,
  input  logic              bypNew,
  output logic              atBoundary,
  output logic              cardClk,
  output logic              clkTick
);

  logic [PER_W-1:0] cnt, perCur, hiCur, cntInc;
  logic             running, bypassCur, cardClkQ, bypGate;
  logic             nextRun, nextByp;

  assign hiCur      = perCur >> 1;
  assign cntInc     = cnt + PER_W'(1);
  assign atBoundary = !running || (cntInc == perCur);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      bypassCur <= 1'b0;
      cnt       <= '0;
      perCur    <= PER_W'(2);
      cardClkQ  <= 1'b0;
      clkTick   <= 1'b0;
    end else if (strobe.go) begin
      running   <= 1'b1;
      bypassCur <= bypNew;
      cnt       <= '0;
      perCur    <= perNew;
      cardClkQ  <= !bypNew;
      clkTick   <= 1'b1;
    end else if (strobe.park) begin
      running   <= 1'b0;
      bypassCur <= 1'b0;
      cnt       <= '0;
      cardClkQ  <= 1'b0;
      clkTick   <= 1'b0;
    end else begin
      cnt       <= cntInc;
      cardClkQ  <= (cntInc < hiCur);
      clkTick   <= 1'b0;
    end
  end

  // Gate for the pass-through clock: the value for the coming cycle, settled while clk is low.
  always_comb begin
    nextRun = running;
    nextByp = bypassCur;
    if (strobe.go) begin
      nextRun = 1'b1;
      nextByp = bypNew;
    end else if (strobe.park) begin
      nextRun = 1'b0;
      nextByp = 1'b0;
    end
  end

  always_ff @(negedge clk) begin
    if (!rstN) bypGate <= 1'b0;
    else       bypGate <= nextRun && nextByp;
  end

  assign cardClk = cardClkQ | (clk & bypGate);

  // High-phase length tracker for the no-short-pulse check.
  logic [PER_W-1:0] hiRun;
  always_ff @(posedge clk) begin
    if (!rstN)         hiRun <= '0;
    else if (clkTick && !cardClkQ) hiRun <= '0;
    else if (cardClkQ) hiRun <= (strobe.go ? PER_W'(1) : hiRun + PER_W'(1));
    else               hiRun <= '0;
  end

  // R9
  tick_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkTick && !bypassCur) |-> (cardClkQ && !$past(cardClkQ)));

  // R8
  full_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cardClkQ) |-> (hiRun == hiCur));

  // R5
  park_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.park) |-> (!cardClkQ && !clkTick));

  // R4
  bypass_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && bypassCur) |-> clkTick);

endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
  import cclk_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int ALT_DIV = 0,
  localparam int CFG_W  = DIV_W + 6,
  localparam int PER_W  = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             fifoStall,
  input  logic             pathBusy,
  output logic             cardClk,
  output logic             clkTick,
  output logic [1:0]       busWidth
);

  cclkStrobe_t      strobe;
  logic [PER_W-1:0] perNew;
  logic             bypNew;
  logic             atBoundary;

  cclk_gen_ctrl #(.DIV_W(DIV_W), .ALT_DIV(ALT_DIV)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .fifoStall  (fifoStall),
    .pathBusy   (pathBusy),
    .atBoundary (atBoundary),
    .strobe     (strobe),
    .perNew     (perNew),
    .bypNew     (bypNew),
    .busWidth   (busWidth)
  );

  cclk_gen_dp #(.DIV_W(DIV_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .perNew     (perNew),
    .bypNew     (bypNew),
    .atBoundary (atBoundary),
    .cardClk    (cardClk),
    .clkTick    (clkTick)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!clkTick && busWidth == 2'd0));

endmodule

// File: tb/cclk_gen_tb.sv
module cclk_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [13:0] cfgWrData = '0;
  logic        fifoStall = 1'b0;
  logic        pathBusy = 1'b0;
  logic        cardClk0, clkTick0, cardClk1, clkTick1;
  logic [1:0]  busWidth0, busWidth1;

  int    nChecks = 0;
  int    nFails = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  cclk_gen #(.ALT_DIV(0)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .fifoStall(fifoStall), .pathBusy(pathBusy),
    .cardClk(cardClk0), .clkTick(clkTick0), .busWidth(busWidth0));

  cclk_gen #(.ALT_DIV(1)) u_alt (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .fifoStall(fifoStall), .pathBusy(pathBusy),
    .cardClk(cardClk1), .clkTick(clkTick1), .busWidth(busWidth1));

  // Behavioural period model, one slot per instance (0: even law, 1: integer law).
  int cfg = 0;
  int mRun[2], mPhase[2], mLen[2], mByp[2], mHigh[2], mTick[2];
  int mWidth = 0;

  task automatic modelStep(input int k);
    int  dv, lenNew;
    bit  en, ps, byp, flow, allowed;
    dv   = cfg & 255;
    en   = cfg[8];  ps = cfg[9];  byp = cfg[10];  flow = cfg[11];
    if (mRun[k] == 0 || mPhase[k] == mLen[k] - 1) begin
      allowed = en && !(flow && fifoStall) && !(ps && !pathBusy);
      if (allowed) begin
        lenNew   = byp ? 1 : (k == 1 ? dv + 2 : 2 * (dv + 1));
        mRun[k]  = 1;  mPhase[k] = 0;  mLen[k] = lenNew;  mByp[k] = byp;
        mHigh[k] = byp ? 0 : 1;
        mTick[k] = 1;
      end else begin
        mRun[k] = 0;  mByp[k] = 0;  mHigh[k] = 0;  mTick[k] = 0;
      end
    end else begin
      mPhase[k] = mPhase[k] + 1;
      mHigh[k]  = (mPhase[k] < mLen[k] / 2) ? 1 : 0;
      mTick[k]  = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 2; k++) begin
        mRun[k] = 0; mPhase[k] = 0; mLen[k] = 2; mByp[k] = 0; mHigh[k] = 0; mTick[k] = 0;
      end
      cfg = 0;
      mWidth = 0;
    end else begin
      for (int k = 0; k < 2; k++) modelStep(k);
      if (cfgWrEn) cfg = int'(cfgWrData);
      case ((cfg >> 12) & 3)
        1: mWidth = 1;
        2: mWidth = 2;
        default: mWidth = 0;
      endcase
    end
  end

  function automatic string reqFor(input int k, input string base);
    if (k == 1 && base == "R2") return "R3";
    return base;
  endfunction

  task automatic checkOne(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  // Sample while clk is high: tick, width and the card clock including pass-through.
  always @(posedge clk) begin
    #2;
    if (!done) begin
      checkOne(reqFor(0, tag), "cardClk(hi) std", int'(cardClk0), mHigh[0] | (mRun[0] & mByp[0]));
      checkOne(reqFor(1, tag), "cardClk(hi) alt", int'(cardClk1), mHigh[1] | (mRun[1] & mByp[1]));
      checkOne((tag == "R1") ? "R1" : "R9", "clkTick std", int'(clkTick0), mTick[0]);
      checkOne((tag == "R1") ? "R1" : "R9", "clkTick alt", int'(clkTick1), mTick[1]);
      checkOne((tag == "R1") ? "R1" : "R10", "busWidth std", int'(busWidth0), mWidth);
      checkOne((tag == "R1") ? "R1" : "R10", "busWidth alt", int'(busWidth1), mWidth);
    end
  end

  // Sample while clk is low: the pass-through part must be low.
  always @(negedge clk) begin
    #2;
    if (!done) begin
      checkOne(reqFor(0, tag), "cardClk(lo) std", int'(cardClk0), mHigh[0]);
      checkOne(reqFor(1, tag), "cardClk(lo) alt", int'(cardClk1), mHigh[1]);
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // Field layout: div[7:0], en[8], ps[9], byp[10], flow[11], width[13:12].
  task automatic writeCfg(input int dv, input bit en, input bit ps, input bit byp,
                          input bit flow, input int wd);
    cfgWrData = {wd[1:0], flow, byp, ps, en, dv[7:0]};
    cfgWrEn   = 1'b1;
    waitCycles(1);
    cfgWrEn   = 1'b0;
  endtask

  int cycleCount = 0;
  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 20000 && !done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycleCount);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    tag = "R1";
    rstN = 1'b0;
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(3);

    // R2 / R3 / R11: smallest divider, then a larger one
    tag = "R2";
    writeCfg(0, 1, 0, 0, 0, 0);
    waitCycles(20);
    writeCfg(3, 1, 0, 0, 0, 0);
    waitCycles(40);

    // R8: divider rewritten in the middle of a period
    tag = "R8";
    waitCycles(3);
    writeCfg(6, 1, 0, 0, 0, 0);
    waitCycles(45);
    writeCfg(1, 1, 0, 0, 0, 0);
    waitCycles(30);

    // R9: ticks at odd alternate-law periods
    tag = "R9";
    writeCfg(5, 1, 0, 0, 0, 0);
    waitCycles(40);

    // R4: bypass with two different divider values
    tag = "R4";
    writeCfg(9, 1, 0, 1, 0, 0);
    waitCycles(15);
    writeCfg(200, 1, 0, 1, 0, 0);
    waitCycles(10);
    writeCfg(2, 1, 0, 0, 0, 0);
    waitCycles(20);

    // R6: stall ignored without flow control, honoured with it
    tag = "R6";
    fifoStall = 1'b1;
    waitCycles(20);
    fifoStall = 1'b0;
    writeCfg(2, 1, 0, 0, 1, 0);
    waitCycles(7);
    fifoStall = 1'b1;
    waitCycles(25);
    fifoStall = 1'b0;
    waitCycles(20);
    fifoStall = 1'b1;
    writeCfg(0, 1, 0, 1, 1, 0);
    waitCycles(6);
    fifoStall = 1'b0;
    waitCycles(6);

    // R7: power save follows pathBusy
    tag = "R7";
    writeCfg(1, 1, 1, 0, 0, 0);
    waitCycles(10);
    pathBusy = 1'b1;
    waitCycles(17);
    pathBusy = 1'b0;
    waitCycles(15);

    // R5: enable dropped in the middle of a period
    tag = "R5";
    writeCfg(4, 1, 0, 0, 0, 0);
    waitCycles(13);
    writeCfg(4, 0, 0, 0, 0, 0);
    waitCycles(30);

    // R10: every width code, including the unused one
    tag = "R10";
    for (int w = 0; w < 4; w++) begin
      writeCfg(0, 0, 0, 0, 0, w);
      waitCycles(4);
    end

    // R11: all fields written at once
    tag = "R11";
    pathBusy = 1'b1;
    writeCfg(7, 1, 1, 0, 1, 2);
    waitCycles(40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule